// File: doc/BRIEF.md
# SMI Feature Negotiation and Trigger

This block settles, once per reset, which system-management-interrupt features the guest firmware may use. The host side fixes a 64-bit mask of supported features as a parameter. The guest writes a 64-bit request and then pulses a confirm strobe. If the request asks only for supported bits, the block copies it into the negotiated set and raises an ok flag. After that, the set is fixed until the next reset.

The same block turns writes to the power-management control port into SMI requests. Two command codes switch the ACPI mode flag and never raise an SMI. Any other code raises an SMI, but only when the control-port enable bit of the SMI enable register is set. A negotiated broadcast feature sends that SMI to every CPU. Without it, the SMI goes only to the CPU that issued the write. A lock bit in the power-management configuration register freezes itself and the global enable bit of the SMI enable register until reset.

Top module: `smi_negotiator`

## Requirements
- R1: After reset, the requested set, the negotiated set, the ok flag, the configuration register, the SMI enable register, the ACPI mode flag and all SMI outputs read zero.
- R2: A confirm with the ok flag clear, where the request holds any bit outside the host mask (default mask 0x1), leaves the ok flag at 0 and the negotiated set unchanged.
- R3: A confirm with the ok flag clear and a request inside the host mask copies the request into the negotiated set and sets the ok flag. Both show in the cycle after the strobe.
- R4: Once the ok flag is set, further confirm strobes are ignored, and the negotiated set holds even when the request register is rewritten.
- R5: A control-port write of the enable code (default 0xF1) sets the ACPI mode flag. A write of the disable code (default 0xF0) clears it. Neither raises an SMI.
- R6: Any other control-port write raises an SMI only if bit 5 of the SMI enable register is set. The SMI is a one-cycle pulse in the cycle after the write.
- R7: With bit 0 (broadcast) of the negotiated set at 1, the SMI drives every bit of the per-CPU output. Otherwise it drives only the bit indexed by the issuing-CPU input.
- R8: Once bit 4 (lock) of the configuration register is 1, writes cannot clear it. The other bits of that register stay writable.
- R9: While the lock bit is set, bit 0 of the SMI enable register keeps its value across writes. Its other bits stay writable.
- R10: Reset clears the negotiation and the lock but not the host mask, so a valid request is accepted again after reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_wr_i | input | 1 | Write strobe for the requested feature set |
| req_data_i | input | 64 | Requested feature set |
| confirm_i | input | 1 | Confirm strobe; validates and locks the request |
| pmcon_wr_i | input | 1 | Write strobe for the configuration register |
| pmcon_data_i | input | 16 | Configuration register write data |
| smi_en_wr_i | input | 1 | Write strobe for the SMI enable register |
| smi_en_data_i | input | 32 | SMI enable register write data |
| apm_wr_i | input | 1 | Control-port write strobe |
| apm_data_i | input | 8 | Control-port command code |
| apm_cpu_i | input | 2 | Index of the CPU issuing the control-port write |
| requested_o | output | 64 | Current requested feature set |
| negotiated_o | output | 64 | Negotiated feature set |
| feat_ok_o | output | 1 | Negotiation complete flag |
| pmcon_o | output | 16 | Configuration register |
| smi_en_o | output | 32 | SMI enable register |
| acpi_mode_o | output | 1 | ACPI mode flag |
| smi_o | output | 4 | Per-CPU SMI request pulses |

## Verification
The hardest states to reach from the ports are the ones that exist only after earlier steps. A broadcast SMI needs a successful negotiation of bit 0 first. A frozen enable bit needs the lock set while that bit already holds a value worth keeping. The bench runs its control-port vector table while a unicast subset (the empty set) is negotiated. It then writes 1 to enable bit 0 before setting the lock, so that the later attempts to clear the bit can be observed. After a mid-run reset, it negotiates the broadcast bit to show that the host mask survived and that delivery switches to all CPUs.

// File: rtl/smi_negotiator.sv
module smi_negotiator #(
  parameter int                NCPU          = 4,
  parameter int                FEAT_W        = 64,
  parameter logic [FEAT_W-1:0] HOST_FEATURES = 64'h1,
  parameter int                BCAST_BIT     = 0,
  parameter logic [7:0]        ACPI_EN_CMD   = 8'hF1,
  parameter logic [7:0]        ACPI_DIS_CMD  = 8'hF0,
  parameter int                SMI_EN_W      = 32,
  parameter int                APMC_BIT      = 5,
  parameter int                PMCON_W       = 16,
  parameter int                LOCK_BIT      = 4,
  localparam int               IDX_W         = (NCPU > 1) ? $clog2(NCPU) : 1
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                req_wr_i,
  input  logic [FEAT_W-1:0]   req_data_i,
  input  logic                confirm_i,
  input  logic                pmcon_wr_i,
  input  logic [PMCON_W-1:0]  pmcon_data_i,
  input  logic                smi_en_wr_i,
  input  logic [SMI_EN_W-1:0] smi_en_data_i,
  input  logic                apm_wr_i,
  input  logic [7:0]          apm_data_i,
  input  logic [IDX_W-1:0]    apm_cpu_i,
  output logic [FEAT_W-1:0]   requested_o,
  output logic [FEAT_W-1:0]   negotiated_o,
  output logic                feat_ok_o,
  output logic [PMCON_W-1:0]  pmcon_o,
  output logic [SMI_EN_W-1:0] smi_en_o,
  output logic                acpi_mode_o,
  output logic [NCPU-1:0]     smi_o
);

  logic            req_fits;
  logic            locked;
  logic            acpi_cmd;
  logic            fire;
  logic [NCPU-1:0] target;

  assign req_fits = (requested_o & ~HOST_FEATURES) == '0;
  assign locked   = pmcon_o[LOCK_BIT];
  assign acpi_cmd = (apm_data_i == ACPI_EN_CMD) || (apm_data_i == ACPI_DIS_CMD);
  assign fire     = apm_wr_i && !acpi_cmd && smi_en_o[APMC_BIT];
  assign target   = negotiated_o[BCAST_BIT] ? {NCPU{1'b1}}
                                            : NCPU'(1) << apm_cpu_i;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      requested_o  <= '0;
      negotiated_o <= '0;
      feat_ok_o    <= 1'b0;
    end else begin
      if (req_wr_i) requested_o <= req_data_i;
      if (confirm_i && !feat_ok_o && req_fits) begin
        negotiated_o <= requested_o;
        feat_ok_o    <= 1'b1;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pmcon_o  <= '0;
      smi_en_o <= '0;
    end else begin
      if (pmcon_wr_i) begin
        pmcon_o           <= pmcon_data_i;
        pmcon_o[LOCK_BIT] <= pmcon_data_i[LOCK_BIT] | locked;
      end
      if (smi_en_wr_i) begin
        smi_en_o    <= smi_en_data_i;
        smi_en_o[0] <= locked ? smi_en_o[0] : smi_en_data_i[0];
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      acpi_mode_o <= 1'b0;
      smi_o       <= '0;
    end else begin
      if (apm_wr_i && apm_data_i == ACPI_EN_CMD)  acpi_mode_o <= 1'b1;
      if (apm_wr_i && apm_data_i == ACPI_DIS_CMD) acpi_mode_o <= 1'b0;
      smi_o <= fire ? target : '0;
    end
  end

  p_reset_state_r1: assert property (@(posedge clk)
    !rst_n |=> (feat_ok_o == 1'b0 && smi_o == '0 && pmcon_o == '0));

  p_reject_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (confirm_i && !feat_ok_o && (requested_o & ~HOST_FEATURES) != '0)
      |=> (!feat_ok_o && $stable(negotiated_o)));

  p_accept_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (confirm_i && !feat_ok_o && (requested_o & ~HOST_FEATURES) == '0)
      |=> (feat_ok_o && negotiated_o == $past(requested_o)));

  p_locked_set_r4: assert property (@(posedge clk) disable iff (!rst_n)
    feat_ok_o |=> (feat_ok_o && $stable(negotiated_o)));

  p_acpi_no_smi_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (apm_wr_i && (apm_data_i == ACPI_EN_CMD || apm_data_i == ACPI_DIS_CMD))
      |=> (smi_o == '0));

  p_smi_needs_write_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (!apm_wr_i || !smi_en_o[APMC_BIT]) |=> (smi_o == '0));

  p_unicast_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (apm_wr_i && !negotiated_o[BCAST_BIT]) |=> $onehot0(smi_o));

  p_lock_sticky_r8: assert property (@(posedge clk) disable iff (!rst_n)
    pmcon_o[LOCK_BIT] |=> pmcon_o[LOCK_BIT]);

  p_enable_frozen_r9: assert property (@(posedge clk) disable iff (!rst_n)
    pmcon_o[LOCK_BIT] |=> $stable(smi_en_o[0]));

endmodule

// File: tb/smi_negotiator_tb.sv
module smi_negotiator_tb;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_wr_i = 1'b0;
  logic [63:0] req_data_i = '0;
  logic        confirm_i = 1'b0;
  logic        pmcon_wr_i = 1'b0;
  logic [15:0] pmcon_data_i = '0;
  logic        smi_en_wr_i = 1'b0;
  logic [31:0] smi_en_data_i = '0;
  logic        apm_wr_i = 1'b0;
  logic [7:0]  apm_data_i = '0;
  logic [1:0]  apm_cpu_i = '0;
  logic [63:0] requested_o, negotiated_o;
  logic        feat_ok_o, acpi_mode_o;
  logic [15:0] pmcon_o;
  logic [31:0] smi_en_o;
  logic [3:0]  smi_o;

  int checks = 0;
  int failures = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  smi_negotiator u_dut (
    .clk(clk), .rst_n(rst_n),
    .req_wr_i(req_wr_i), .req_data_i(req_data_i), .confirm_i(confirm_i),
    .pmcon_wr_i(pmcon_wr_i), .pmcon_data_i(pmcon_data_i),
    .smi_en_wr_i(smi_en_wr_i), .smi_en_data_i(smi_en_data_i),
    .apm_wr_i(apm_wr_i), .apm_data_i(apm_data_i), .apm_cpu_i(apm_cpu_i),
    .requested_o(requested_o), .negotiated_o(negotiated_o), .feat_ok_o(feat_ok_o),
    .pmcon_o(pmcon_o), .smi_en_o(smi_en_o), .acpi_mode_o(acpi_mode_o), .smi_o(smi_o)
  );

  // {code[14:7], cpu[6:5], expected smi[4:1], expected acpi mode[0]}
  localparam logic [14:0] VEC [7] = '{
    {8'hF1, 2'd0, 4'b0000, 1'b1},
    {8'h55, 2'd2, 4'b0100, 1'b1},
    {8'hF0, 2'd1, 4'b0000, 1'b0},
    {8'h00, 2'd3, 4'b1000, 1'b0},
    {8'hFF, 2'd0, 4'b0001, 1'b0},
    {8'hF1, 2'd3, 4'b0000, 1'b1},
    {8'hF2, 2'd1, 4'b0010, 1'b1}
  };

  task automatic check(input string req, input logic [63:0] got, input logic [63:0] exp);
    checks++;
    if (got !== exp) begin
      failures++;
      $display("FAIL %s got=%h exp=%h", req, got, exp);
    end
  endtask

  task automatic do_reset();
    @(negedge clk) rst_n = 1'b0;
    @(negedge clk);
    @(negedge clk) rst_n = 1'b1;
  endtask

  task automatic set_req(input logic [63:0] d);
    @(negedge clk) begin req_wr_i = 1'b1; req_data_i = d; end
    @(negedge clk) req_wr_i = 1'b0;
  endtask

  task automatic confirm();
    @(negedge clk) confirm_i = 1'b1;
    @(negedge clk) confirm_i = 1'b0;
  endtask

  task automatic wr_pmcon(input logic [15:0] d);
    @(negedge clk) begin pmcon_wr_i = 1'b1; pmcon_data_i = d; end
    @(negedge clk) pmcon_wr_i = 1'b0;
  endtask

  task automatic wr_smi_en(input logic [31:0] d);
    @(negedge clk) begin smi_en_wr_i = 1'b1; smi_en_data_i = d; end
    @(negedge clk) smi_en_wr_i = 1'b0;
  endtask

  task automatic apm(input logic [7:0] code, input logic [1:0] cpu);
    @(negedge clk) begin apm_wr_i = 1'b1; apm_data_i = code; apm_cpu_i = cpu; end
    @(negedge clk) apm_wr_i = 1'b0;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    failures++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    do_reset();
    // R1 reset state
    check("R1 ok", feat_ok_o, 0);
    check("R1 negotiated", negotiated_o, 0);
    check("R1 requested", requested_o, 0);
    check("R1 pmcon", pmcon_o, 0);
    check("R1 smi_en", smi_en_o, 0);
    check("R1 acpi", acpi_mode_o, 0);
    check("R1 smi", smi_o, 0);

    // R2 request outside host mask
    set_req(64'h8000_0000_0000_0001);
    confirm();
    check("R2 ok stays 0", feat_ok_o, 0);
    check("R2 negotiated unchanged", negotiated_o, 0);
    set_req(64'h2);
    confirm();
    check("R2 ok stays 0 (bit1)", feat_ok_o, 0);

    // R3 empty subset is valid
    set_req(64'h0);
    confirm();
    check("R3 ok set", feat_ok_o, 1);
    check("R3 negotiated", negotiated_o, 0);

    // R4 later confirm ignored
    set_req(64'h1);
    check("R4 request rewritten", requested_o, 64'h1);
    confirm();
    check("R4 negotiated held", negotiated_o, 0);
    check("R4 ok held", feat_ok_o, 1);

    // R6 enable bit clear: no SMI
    apm(8'h55, 2'd1);
    check("R6 no smi when disabled", smi_o, 0);

    // R5 R6 R7 vector walk, unicast
    wr_smi_en(32'h20);
    foreach (VEC[i]) begin
      apm(VEC[i][14:7], VEC[i][6:5]);
      check("R5/R7 smi vector", smi_o, VEC[i][4:1]);
      check("R5 acpi mode", acpi_mode_o, VEC[i][0]);
      @(negedge clk);
      check("R6 single-cycle pulse", smi_o, 0);
    end

    // R8 R9 lock behaviour
    wr_smi_en(32'h21);
    wr_pmcon(16'h0010);
    check("R8 lock set", pmcon_o, 16'h0010);
    wr_pmcon(16'h0003);
    check("R8 lock sticky, others writable", pmcon_o, 16'h0013);
    wr_smi_en(32'h20);
    check("R9 bit0 frozen", smi_en_o, 32'h21);
    wr_smi_en(32'h0);
    check("R9 bit0 frozen, bit5 writable", smi_en_o, 32'h01);
    apm(8'h55, 2'd0);
    check("R6 no smi after enable cleared", smi_o, 0);

    // R10 reset keeps host mask
    do_reset();
    check("R10 ok cleared", feat_ok_o, 0);
    check("R10 lock cleared", pmcon_o, 0);
    check("R10 negotiated cleared", negotiated_o, 0);
    set_req(64'h1);
    confirm();
    check("R10 broadcast accepted", feat_ok_o, 1);
    check("R10 negotiated", negotiated_o, 64'h1);
    wr_smi_en(32'h20);
    apm(8'h33, 2'd1);
    check("R7 broadcast", smi_o, 4'b1111);
    @(negedge clk);
    check("R6 broadcast pulse ends", smi_o, 0);
    apm(8'hF0, 2'd2);
    check("R5 disable code no smi in broadcast", smi_o, 0);

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule